// File: doc/BRIEF.md
# Banked and Indirect Data Address Unit

This unit produces the 12-bit data-memory address for every operand access of a small 8-bit core. The 4096-byte data space is divided into sixteen 256-byte pages. An instruction supplies an 8-bit register field and a one-bit mode flag. With the flag set, the page comes from a 4-bit page register. With the flag clear, the field selects a fixed window that joins the bottom 96 bytes of the space to the top 160 bytes. The memory array itself lives outside the unit.

Three 12-bit pointer registers give indirect access. Each pointer is reached through five virtual addresses in the top page. Depending on which one the direct address hits, the unit uses the pointer as it stands, uses it and then steps it up or down, steps it up and uses the new value, or adds the working register to it as a signed offset. The address is combinational from the current inputs. Pointer and page-register changes take effect at the clock edge that ends the access.

Top module: `dau_addr_unit`

## Requirements
- R1: After reset, the page register and all three pointers read zero.
- R2: With `banked`=1 and no virtual hit, `eff_addr` = {page register, `f_field`}.
- R3: With `banked`=0 and `f_field` below 0x60, `eff_addr` = 0x000 + `f_field`.
- R4: With `banked`=0 and `f_field` at or above 0x60, the direct address is 0xF00 + `f_field`. It is used as is unless it is a virtual address.
- R5: `bsr_we`=1 loads `bsr_wdata` into the page register at the next edge. Otherwise the page register holds. An access in the same cycle still uses the old page.
- R6: `ptr_we`=1 writes `ptr_wdata` into the pointer chosen by `ptr_wsel` (0, 1 or 2) at the next edge. This write wins over any access update to the same pointer in that cycle.
- R7: Pointer k (k = 0, 1, 2) owns direct addresses 0xFEB−8k to 0xFEF−8k. Offset +4 is plain, +3 is post-increment, +2 is post-decrement, +1 is pre-increment and +0 is plus-working-register. On a hit, `indirect_hit`=1 and `eff_addr` comes from the pointer. With no hit, `indirect_hit`=0.
- R8: Post-increment and post-decrement present the current pointer value as `eff_addr`. If `acc_en`=1, the pointer changes by +1 or −1 at the next edge.
- R9: Pre-increment presents pointer+1 as `eff_addr`. If `acc_en`=1, the pointer becomes pointer+1.
- R10: Plus-working-register presents pointer + sign-extended `wreg`. The pointer does not change. Plain access also leaves the pointer unchanged.
- R11: All pointer arithmetic wraps modulo 4096.
- R12: With `acc_en`=0, addresses are still formed but no pointer changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| f_field | input | 8 | Register field of the instruction |
| banked | input | 1 | 1: page register selects the page; 0: fixed split window |
| acc_en | input | 1 | Access completes this cycle (read or write strobe) |
| wreg | input | 8 | Working register, signed offset for plus-working-register mode |
| bsr_we | input | 1 | Page register load |
| bsr_wdata | input | 4 | New page number |
| ptr_we | input | 1 | Pointer load |
| ptr_wsel | input | 2 | Pointer chosen for load |
| ptr_wdata | input | 12 | New pointer value |
| eff_addr | output | 12 | Effective data address |
| indirect_hit | output | 1 | Access goes through a pointer |
| bank_q | output | 4 | Page register |
| ptr_q | output | 36 | Pointers; pointer k at bits 12k+11 to 12k |

## Verification
The properties assume `ptr_wsel` never selects a pointer that does not exist. The bench only drives 0 to 2. The page-based address property assumes the page register is not 0xF, because in that page the field could reach a virtual address. The stimulus covers that page in a separate, model-checked step. The pointer-update properties look only at pointer 0 through fixed field values. For the other pointers the bench relies on its reference model, with wrap-around exercised at 0x000 and 0xFFF.

// File: rtl/dau_pkg.sv
package dau_pkg;
  localparam int ADDR_W  = 12;
  localparam int BANK_W  = 4;
  localparam int FIELD_W = 8;

  // low three bits of a virtual address select the access kind
  typedef enum logic [2:0] {
    VM_PLUSW   = 3'd3,
    VM_PREINC  = 3'd4,
    VM_POSTDEC = 3'd5,
    VM_POSTINC = 3'd6,
    VM_PLAIN   = 3'd7
  } vmode_e;
endpackage

// File: rtl/dau_direct.sv
module dau_direct
  import dau_pkg::*;
#(
  parameter logic [FIELD_W-1:0] ACC_SPLIT = 8'h60
) (
  input  logic               banked,
  input  logic [BANK_W-1:0]  bank_q,
  input  logic [FIELD_W-1:0] f_field,
  output logic [ADDR_W-1:0]  dir_addr
);
  localparam logic [BANK_W-1:0] LO_PAGE = '0;
  localparam logic [BANK_W-1:0] HI_PAGE = '1;

  always_comb begin
    if (banked)
      dir_addr = {bank_q, f_field};
    else if (f_field < ACC_SPLIT)
      dir_addr = {LO_PAGE, f_field};
    else
      dir_addr = {HI_PAGE, f_field};
  end
endmodule

// File: rtl/dau_ptr_slot.sv
module dau_ptr_slot
  import dau_pkg::*;
#(
  parameter logic [ADDR_W-1:0] GROUP_BASE = 12'hFE8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  dir_addr,
  input  logic [FIELD_W-1:0] wreg,
  input  logic               acc_en,
  input  logic               ld_en,
  input  logic [ADDR_W-1:0]  ld_val,
  output logic               hit,
  output logic [ADDR_W-1:0]  ea,
  output logic [ADDR_W-1:0]  ptr_o
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] ptr_r, ptr_d, ofs;
  logic [2:0]        sel;
  logic              ptr_en;

  assign sel = dir_addr[2:0];
  assign hit = (dir_addr[ADDR_W-1:3] == GROUP_BASE[ADDR_W-1:3]) &&
               (sel >= VM_PLUSW);
  assign ofs = {{(ADDR_W-FIELD_W){wreg[FIELD_W-1]}}, wreg};

  always_comb begin
    ea    = ptr_r;
    ptr_d = ptr_r;
    case (sel)
      VM_PLUSW:   ea = ptr_r + ofs;
      VM_PREINC: begin
        ea    = ptr_r + ONE;
        ptr_d = ptr_r + ONE;
      end
      VM_POSTDEC: ptr_d = ptr_r - ONE;
      VM_POSTINC: ptr_d = ptr_r + ONE;
      default: ;
    endcase
    if (ld_en) ptr_d = ld_val;
  end

  assign ptr_en = ld_en || (acc_en && hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_r <= '0;
    else if (ptr_en) ptr_r <= ptr_d;
  end

  assign ptr_o = ptr_r;
endmodule

// File: rtl/dau_addr_unit.sv
module dau_addr_unit
  import dau_pkg::*;
#(
  parameter int                  NPTR         = 3,
  parameter logic [FIELD_W-1:0]  ACC_SPLIT    = 8'h60,
  parameter logic [ADDR_W-1:0]   TOP_GROUP    = 12'hFE8,
  parameter int                  GROUP_STRIDE = 8,
  localparam int                 SEL_W        = $clog2(NPTR)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [FIELD_W-1:0]       f_field,
  input  logic                     banked,
  input  logic                     acc_en,
  input  logic [FIELD_W-1:0]       wreg,
  input  logic                     bsr_we,
  input  logic [BANK_W-1:0]        bsr_wdata,
  input  logic                     ptr_we,
  input  logic [SEL_W-1:0]         ptr_wsel,
  input  logic [ADDR_W-1:0]        ptr_wdata,
  output logic [ADDR_W-1:0]        eff_addr,
  output logic                     indirect_hit,
  output logic [BANK_W-1:0]        bank_q,
  output logic [NPTR*ADDR_W-1:0]   ptr_q
);
  logic [ADDR_W-1:0] dir_addr;
  logic [BANK_W-1:0] bank_r, bank_d;
  logic [NPTR-1:0]   hit_v;
  logic [ADDR_W-1:0] ea_v [NPTR];

  always_comb begin
    bank_d = bank_r;
    if (bsr_we) bank_d = bsr_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_r <= '0;
    else        bank_r <= bank_d;
  end

  assign bank_q = bank_r;

  dau_direct #(.ACC_SPLIT(ACC_SPLIT)) u_direct (
    .banked   (banked),
    .bank_q   (bank_r),
    .f_field  (f_field),
    .dir_addr (dir_addr)
  );

  for (genvar k = 0; k < NPTR; k++) begin : g_slot
    localparam logic [ADDR_W-1:0] BASE = TOP_GROUP - ADDR_W'(k * GROUP_STRIDE);
    dau_ptr_slot #(.GROUP_BASE(BASE)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .dir_addr (dir_addr),
      .wreg     (wreg),
      .acc_en   (acc_en),
      .ld_en    (ptr_we && (ptr_wsel == SEL_W'(k))),
      .ld_val   (ptr_wdata),
      .hit      (hit_v[k]),
      .ea       (ea_v[k]),
      .ptr_o    (ptr_q[k*ADDR_W +: ADDR_W])
    );
  end

  always_comb begin
    eff_addr     = dir_addr;
    indirect_hit = |hit_v;
    for (int k = 0; k < NPTR; k++)
      if (hit_v[k]) eff_addr = ea_v[k];
  end
endmodule

// File: rtl/dau_addr_unit_chk.sv
module dau_addr_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  f_field,
  input logic        banked,
  input logic        acc_en,
  input logic        bsr_we,
  input logic [3:0]  bsr_wdata,
  input logic        ptr_we,
  input logic [1:0]  ptr_wsel,
  input logic [11:0] ptr_wdata,
  input logic [11:0] eff_addr,
  input logic [3:0]  bank_q,
  input logic [35:0] ptr_q
);
  logic [11:0] p0;
  logic        dir_ptr0;
  assign p0       = ptr_q[11:0];
  assign dir_ptr0 = acc_en && !ptr_we && !banked;

  // R2
  banked_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    banked && bank_q != 4'hF |-> eff_addr == {bank_q, f_field});
  // R3
  low_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !banked && f_field < 8'h60 |-> eff_addr == {4'h0, f_field});
  // R4
  high_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !banked && f_field >= 8'h60 && f_field < 8'hDB |-> eff_addr == {4'hF, f_field});
  // R5
  bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bsr_we |=> bank_q == $past(bsr_wdata));
  // R5
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bsr_we |=> $stable(bank_q));
  // R6
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_we && ptr_wsel == 2'd0 |=> p0 == $past(ptr_wdata));
  // R8
  postinc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_ptr0 && f_field == 8'hEE |=> p0 == $past(p0) + 12'd1);
  // R8
  postinc_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !banked && f_field == 8'hEE |-> eff_addr == p0);
  // R9
  preinc_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !banked && f_field == 8'hEC |-> eff_addr == p0 + 12'd1);
  // R10
  plusw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_ptr0 && f_field == 8'hEB |=> $stable(p0));
  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en && !ptr_we |=> $stable(ptr_q));
endmodule

bind dau_addr_unit dau_addr_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .f_field   (f_field),
  .banked    (banked),
  .acc_en    (acc_en),
  .bsr_we    (bsr_we),
  .bsr_wdata (bsr_wdata),
  .ptr_we    (ptr_we),
  .ptr_wsel  (ptr_wsel),
  .ptr_wdata (ptr_wdata),
  .eff_addr  (eff_addr),
  .bank_q    (bank_q),
  .ptr_q     (ptr_q)
);

// File: tb/dau_addr_unit_tb.sv
module dau_addr_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  f_field = '0;
  logic        banked = 1'b0;
  logic        acc_en = 1'b0;
  logic [7:0]  wreg = '0;
  logic        bsr_we = 1'b0;
  logic [3:0]  bsr_wdata = '0;
  logic        ptr_we = 1'b0;
  logic [1:0]  ptr_wsel = '0;
  logic [11:0] ptr_wdata = '0;
  logic [11:0] eff_addr;
  logic        indirect_hit;
  logic [3:0]  bank_q;
  logic [35:0] ptr_q;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dau_addr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .f_field(f_field), .banked(banked),
    .acc_en(acc_en), .wreg(wreg), .bsr_we(bsr_we), .bsr_wdata(bsr_wdata),
    .ptr_we(ptr_we), .ptr_wsel(ptr_wsel), .ptr_wdata(ptr_wdata),
    .eff_addr(eff_addr), .indirect_hit(indirect_hit), .bank_q(bank_q),
    .ptr_q(ptr_q)
  );

  // reference state
  logic [11:0] mp [3];
  logic [3:0]  mb;

  // scoreboard queues
  logic [11:0] q_ea   [$];
  logic        q_hit  [$];
  logic [35:0] q_ptr  [$];
  logic [3:0]  q_bank [$];
  string       q_req  [$];

  task automatic check(string req, string what, logic [35:0] act, logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(string req, logic bk, logic [7:0] f, logic en, logic [7:0] w,
                      logic bwe, logic [3:0] bd, logic pwe, logic [1:0] ps,
                      logic [11:0] pd);
    logic [11:0] dir, ea, np [3];
    logic        hit;
    @(posedge clk);
    #2;
    banked = bk; f_field = f; acc_en = en; wreg = w;
    bsr_we = bwe; bsr_wdata = bd; ptr_we = pwe; ptr_wsel = ps; ptr_wdata = pd;
    if (bk)           dir = {mb, f};
    else if (f < 8'h60) dir = {4'h0, f};
    else              dir = {4'hF, f};
    ea = dir; hit = 1'b0;
    for (int k = 0; k < 3; k++) np[k] = mp[k];
    for (int k = 0; k < 3; k++) begin
      logic [11:0] base;
      base = 12'hFEB - 12'(8 * k);
      if (dir >= base && dir <= base + 12'd4) begin
        hit = 1'b1;
        case (dir - base)
          12'd4: ea = mp[k];
          12'd3: begin ea = mp[k]; if (en) np[k] = mp[k] + 12'd1; end
          12'd2: begin ea = mp[k]; if (en) np[k] = mp[k] - 12'd1; end
          12'd1: begin ea = mp[k] + 12'd1; if (en) np[k] = mp[k] + 12'd1; end
          default: ea = mp[k] + {{4{w[7]}}, w};
        endcase
      end
    end
    if (pwe) np[ps] = pd;
    q_ea.push_back(ea); q_hit.push_back(hit);
    q_ptr.push_back({mp[2], mp[1], mp[0]}); q_bank.push_back(mb); q_req.push_back(req);
    for (int k = 0; k < 3; k++) mp[k] = np[k];
    if (bwe) mb = bd;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (q_ea.size() > 0) begin
        string r;
        r = q_req.pop_front();
        check(r, "eff_addr", 36'(eff_addr), 36'(q_ea.pop_front()));
        check(r, "indirect_hit", 36'(indirect_hit), 36'(q_hit.pop_front()));
        check(r, "ptr_q", ptr_q, q_ptr.pop_front());
        check(r, "bank_q", 36'(bank_q), 36'(q_bank.pop_front()));
      end
    end
  end

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int k = 0; k < 3; k++) mp[k] = '0;
    mb = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "ptr_q", ptr_q, 36'h0);
    check("R1", "bank_q", 36'(bank_q), 36'h0);
    // R6 loads
    step("R6", 1'b0, 8'h10, 1'b0, 8'h00, 1'b0, 4'h0, 1'b1, 2'd0, 12'h123);
    step("R6", 1'b0, 8'h10, 1'b0, 8'h00, 1'b0, 4'h0, 1'b1, 2'd1, 12'hFFF);
    step("R6", 1'b0, 8'h10, 1'b0, 8'h00, 1'b0, 4'h0, 1'b1, 2'd2, 12'h000);
    // R5 page load; same-cycle access uses old page
    step("R5", 1'b1, 8'h34, 1'b1, 8'h00, 1'b1, 4'h5, 1'b0, 2'd0, 12'h000);
    step("R2", 1'b1, 8'h34, 1'b1, 8'h00, 1'b0, 4'h0, 1'b0, 2'd0, 12'h000);
    step("R2", 1'b1, 8'hEE, 1'b1, 8'h00, 1'b0, 4'h0, 1'b0, 2'd0, 12'h000);
    step("R3", 1'b0, 8'h5F, 1'b1, 8'h00, 1'b0, 4'h0, 1'b0, 2'd0, 12'h000);
    step("R3", 1'b0, 8'h00, 1'b1, 8'h00, 1'b0, 4'h0, 1'b0, 2'd0, 12'h000);
    step("R4", 1'b0, 8'h60, 1'b1, 8'h00, 1'b0, 4'h0, 1'b0, 2'd0, 12'h000);
    step("R4", 1'b0, 8'hEA, 1'b1, 8'h00, 1'b0, 4'h0, 1'b0, 2'd0, 12'h000);
    step("R7", 1'b0, 8'hEF, 1'b1, 8'h00, 1'b0, 4'h0, 1'b0, 2'd0, 12'h000);
    step("R8", 1'b0, 8'hEE, 1'b1, 8'h00, 1'b0, 4'h0, 1'b0, 2'd0, 12'h000);
    step("R8", 1'b0, 8'hED, 1'b1, 8'h00, 1'b0, 4'h0, 1'b0, 2'd0, 12'h000);
    step("R8", 1'b0, 8'hED, 1'b1, 8'h00, 1'b0, 4'h0, 1'b0, 2'd0, 12'h000);
    step("R9", 1'b0, 8'hE4, 1'b1, 8'h00, 1'b0, 4'h0, 1'b0, 2'd0, 12'h000);
    step("R11", 1'b0, 8'hDD, 1'b1, 8'h00, 1'b0, 4'h0, 1'b0, 2'd0, 12'h000);
    step("R10", 1'b0, 8'hDB, 1'b1, 8'h80, 1'b0, 4'h0, 1'b0, 2'd0, 12'h000);
    step("R10", 1'b0, 8'hEB, 1'b1, 8'h05, 1'b0, 4'h0, 1'b0, 2'd0, 12'h000);
    step("R10", 1'b0, 8'hE7, 1'b1, 8'h00, 1'b0, 4'h0, 1'b0, 2'd0, 12'h000);
    step("R12", 1'b0, 8'hEE, 1'b0, 8'h00, 1'b0, 4'h0, 1'b0, 2'd0, 12'h000);
    step("R12", 1'b0, 8'hDC, 1'b0, 8'h00, 1'b0, 4'h0, 1'b0, 2'd0, 12'h000);
    step("R6", 1'b0, 8'hEE, 1'b1, 8'h00, 1'b0, 4'h0, 1'b1, 2'd0, 12'h800);
    step("R7", 1'b0, 8'hE0, 1'b1, 8'h00, 1'b1, 4'hF, 1'b0, 2'd0, 12'h000);
    step("R7", 1'b1, 8'hE6, 1'b1, 8'h00, 1'b0, 4'h0, 1'b0, 2'd0, 12'h000);
    step("R11", 1'b0, 8'hDE, 1'b1, 8'h00, 1'b0, 4'h0, 1'b0, 2'd0, 12'h000);
    step("R5", 1'b0, 8'h10, 1'b0, 8'h00, 1'b0, 4'h0, 1'b0, 2'd0, 12'h000);
    step("R12", 1'b0, 8'h10, 1'b0, 8'h00, 1'b0, 4'h0, 1'b0, 2'd0, 12'h000);
    @(posedge clk);
    #2;
    acc_en = 1'b0; ptr_we = 1'b0; bsr_we = 1'b0;
    while (q_ea.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule